// File: doc/BRIEF.md
# Frame-Indexed Reverse Translation Search

This block turns a virtual address into a physical address using a reverse-mapped table. The table has one slot per physical frame, and each slot holds the virtual page number that currently lives in that frame. The table grows with physical memory, not with the virtual space. Translating therefore means searching the table rather than indexing it. The slot number where the page is found becomes the frame number of the result.

A lookup is started by presenting a virtual address with a request strobe while the unit is idle. The controller then reads one slot per clock, starting at slot 0 and counting upward. It stops at the first slot that is both valid and holds the requested page. It reports the result with a one-cycle completion pulse, a hit flag and the physical address. That address is the slot number placed above the untouched page offset.

If every slot has been read without a match, the unit completes with the hit flag low. A separate write port loads a page number into a slot, which marks the slot valid, or invalidates a slot. This port only acts while no search is running.

Top module: `ipt_search_unit`

## Requirements
- R1: After reset, `busy`, `done` and `hit` are 0 and `paddr` is 0. Every slot is invalid, so a first lookup misses.
- R2: A request is taken when `lookup_valid` is 1 and `busy` is 0; `busy` is 1 from the next cycle until the completion cycle. A request presented while `busy` is 1 is ignored and does not change the result of the running search.
- R3: If slot i is the matching slot, `done` pulses for exactly one cycle, i+2 cycles after the clock edge that took the request, with `hit`=1. `busy` is 0 in that same cycle.
- R4: When several valid slots hold the requested page, the lowest-numbered slot is reported.
- R5: When no valid slot holds the page, `done` pulses DEPTH+1 cycles after the request was taken (257 with 256 slots), with `hit`=0 and `paddr`=0.
- R6: A write while `busy` is 0 acts on slot `wr_frame`. With `wr_load`=1 it stores `wr_vpn` and marks the slot valid. With `wr_load`=0 it marks the slot invalid.
- R7: A write presented while `busy` is 1 is dropped: the slot keeps its earlier contents and validity.
- R8: An invalid slot never matches, even if its stored page number equals the requested one.
- R9: `hit` and `paddr` change only in a cycle with `done`=1 (or on reset) and hold their values in between.
- R10: On a hit, `paddr` is the 8-bit slot number in bits 19:12 and the request's bits 11:0 unchanged in bits 11:0. The page number is request bits 31:12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lookup_valid | input | 1 | Start a translation |
| lookup_vaddr | input | 32 | Virtual address: page number in bits 31:12, offset in bits 11:0 |
| wr_en | input | 1 | Table write strobe |
| wr_load | input | 1 | 1 = store page number and mark valid, 0 = invalidate |
| wr_frame | input | 8 | Slot (frame number) to write |
| wr_vpn | input | 20 | Page number to store |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | Last completed search found a match |
| paddr | output | 20 | Frame number over offset from the last completed search |

## Verification
The bench builds the unit with its default widths: 256 slots, 20-bit page numbers and 12-bit offsets. That lets it place matches in slot 0 and slot 255 and run a miss that scans the whole table, so both latency extremes are measured. Sharing a small table also lets it plant duplicate page numbers and invalidated slots. This exercises the lowest-slot-wins rule and the valid-bit gating. Writes and extra requests are placed inside running searches, and a later lookup shows they had no effect.

// File: rtl/ipt_pkg.sv
package ipt_pkg;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } ipt_state_t;

endpackage

// File: rtl/ipt_vpn_ram.sv
// Page-number storage, one word per frame; write port plus registered read,
// written so that block RAM can be inferred (no reset on the array).
module ipt_vpn_ram #(
  parameter int AW = 8,
  parameter int DW = 20
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/ipt_valid_array.sv
// Per-frame valid flags kept in flops so reset can clear them all at once.
module ipt_valid_array #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic          wset,
  input  logic [AW-1:0] raddr,
  output logic          rvld
);
  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] flags;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      rvld  <= 1'b0;
    end else begin
      if (we) flags[waddr] <= wset;
      rvld <= flags[raddr];
    end
  end

endmodule

// File: rtl/ipt_search_ctrl.sv
// Sequential scan controller: issues one slot address per cycle, compares the
// registered read one cycle later, and forms the physical address.
module ipt_search_ctrl
  import ipt_pkg::*;
#(
  parameter int FRAME_W = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     req,
  input  logic [VPN_W+OFF_W-1:0]   vaddr,
  output logic [FRAME_W-1:0]       rd_idx,
  input  logic [VPN_W-1:0]         rd_vpn,
  input  logic                     rd_vld,
  output logic                     busy,
  output logic                     done,
  output logic                     hit,
  output logic [FRAME_W+OFF_W-1:0] paddr
);
  localparam logic [FRAME_W-1:0] LAST_IDX = '1;

  ipt_state_t         state;
  logic [VPN_W-1:0]   want_vpn;
  logic [OFF_W-1:0]   want_off;
  logic [FRAME_W-1:0] issue_idx;
  logic               issue_more;
  logic [FRAME_W-1:0] cmp_idx;
  logic               cmp_live;
  logic               match;
  logic               exhausted;

  assign rd_idx    = issue_idx;
  assign match     = cmp_live && rd_vld && (rd_vpn == want_vpn);
  assign exhausted = cmp_live && (cmp_idx == LAST_IDX) && !match;
  assign busy      = (state == ST_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      want_vpn   <= '0;
      want_off   <= '0;
      issue_idx  <= '0;
      issue_more <= 1'b0;
      cmp_idx    <= '0;
      cmp_live   <= 1'b0;
      done       <= 1'b0;
      hit        <= 1'b0;
      paddr      <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          cmp_live <= 1'b0;
          if (req) begin
            state      <= ST_SCAN;
            want_vpn   <= vaddr[VPN_W+OFF_W-1:OFF_W];
            want_off   <= vaddr[OFF_W-1:0];
            issue_idx  <= '0;
            issue_more <= 1'b1;
          end
        end
        ST_SCAN: begin
          cmp_idx  <= issue_idx;
          cmp_live <= issue_more;
          if (issue_idx == LAST_IDX) issue_more <= 1'b0;
          else                       issue_idx  <= issue_idx + 1'b1;
          if (match) begin
            state    <= ST_IDLE;
            cmp_live <= 1'b0;
            done     <= 1'b1;
            hit      <= 1'b1;
            paddr    <= {cmp_idx, want_off};
          end else if (exhausted) begin
            state    <= ST_IDLE;
            cmp_live <= 1'b0;
            done     <= 1'b1;
            hit      <= 1'b0;
            paddr    <= '0;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ipt_search_unit.sv
module ipt_search_unit #(
  parameter int FRAME_W = 8,
  parameter int VPN_W   = 20,
  parameter int OFF_W   = 12,
  localparam int VA_W   = VPN_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               lookup_valid,
  input  logic [VA_W-1:0]    lookup_vaddr,
  input  logic               wr_en,
  input  logic               wr_load,
  input  logic [FRAME_W-1:0] wr_frame,
  input  logic [VPN_W-1:0]   wr_vpn,
  output logic               busy,
  output logic               done,
  output logic               hit,
  output logic [PA_W-1:0]    paddr
);
  logic               wr_go;
  logic [FRAME_W-1:0] rd_idx;
  logic [VPN_W-1:0]   rd_vpn;
  logic               rd_vld;

  // Table writes only land while no search is running.
  assign wr_go = wr_en && !busy;

  ipt_vpn_ram #(.AW(FRAME_W), .DW(VPN_W)) i_ram (
    .clk   (clk),
    .we    (wr_go && wr_load),
    .waddr (wr_frame),
    .wdata (wr_vpn),
    .raddr (rd_idx),
    .rdata (rd_vpn)
  );

  ipt_valid_array #(.AW(FRAME_W)) i_vld (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_go),
    .waddr (wr_frame),
    .wset  (wr_load),
    .raddr (rd_idx),
    .rvld  (rd_vld)
  );

  ipt_search_ctrl #(.FRAME_W(FRAME_W), .VPN_W(VPN_W), .OFF_W(OFF_W)) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .req    (lookup_valid),
    .vaddr  (lookup_vaddr),
    .rd_idx (rd_idx),
    .rd_vpn (rd_vpn),
    .rd_vld (rd_vld),
    .busy   (busy),
    .done   (done),
    .hit    (hit),
    .paddr  (paddr)
  );

endmodule

// File: rtl/ipt_search_chk.sv
module ipt_search_chk #(
  parameter int FRAME_W = 8,
  parameter int OFF_W   = 12,
  localparam int DEPTH  = 1 << FRAME_W,
  localparam int PA_W   = FRAME_W + OFF_W
) (
  input logic            clk,
  input logic            rst,
  input logic            lookup_valid,
  input logic            busy,
  input logic            done,
  input logic            hit,
  input logic [PA_W-1:0] paddr
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else              busy_run <= busy_run + 1;
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst) (!busy && lookup_valid) |=> busy); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst) done |-> $past(busy)); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R3
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst) (done && !hit) |-> (paddr == '0)); // R5
  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (rst) busy_run <= DEPTH + 1); // R5
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst) !done |-> ($stable(hit) && $stable(paddr))); // R9

endmodule

bind ipt_search_unit ipt_search_chk #(.FRAME_W(FRAME_W), .OFF_W(OFF_W)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .lookup_valid (lookup_valid),
  .busy         (busy),
  .done         (done),
  .hit          (hit),
  .paddr        (paddr)
);

// File: tb/test_ipt_search_unit.sv
`timescale 1ns/1ps
module test_ipt_search_unit;
  localparam int FRAME_W = 8;
  localparam int VPN_W   = 20;
  localparam int OFF_W   = 12;
  localparam int DEPTH   = 1 << FRAME_W;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lookup_valid = 1'b0;
  logic [31:0] lookup_vaddr = '0;
  logic        wr_en = 1'b0;
  logic        wr_load = 1'b0;
  logic [7:0]  wr_frame = '0;
  logic [19:0] wr_vpn = '0;
  logic        busy, done, hit;
  logic [19:0] paddr;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  ipt_search_unit i_ipt_search_unit (
    .clk(clk), .rst(rst), .lookup_valid(lookup_valid), .lookup_vaddr(lookup_vaddr),
    .wr_en(wr_en), .wr_load(wr_load), .wr_frame(wr_frame), .wr_vpn(wr_vpn),
    .busy(busy), .done(done), .hit(hit), .paddr(paddr)
  );

  // Behavioural reference: a table plus a countdown to completion.
  int          m_vpn [DEPTH];
  bit          m_vld [DEPTH];
  bit          m_busy, m_done, m_hit, m_phit;
  int          m_rem;
  logic [19:0] m_paddr, m_ppaddr;
  bit          started = 1'b0;

  always @(posedge clk) begin
    bit was_busy;
    int found;
    started = 1'b1;
    if (rst) begin
      foreach (m_vld[k]) m_vld[k] = 1'b0;
      m_busy = 0; m_done = 0; m_hit = 0; m_paddr = '0; m_rem = 0;
    end else begin
      was_busy = m_busy;
      m_done = 0;
      if (m_busy) begin
        m_rem--;
        if (m_rem == 0) begin
          m_busy = 0; m_done = 1; m_hit = m_phit; m_paddr = m_ppaddr;
        end
      end
      if (wr_en && !was_busy) begin
        m_vld[wr_frame] = wr_load;
        if (wr_load) m_vpn[wr_frame] = int'(wr_vpn);
      end
      if (lookup_valid && !was_busy) begin
        found = -1;
        for (int k = 0; k < DEPTH; k++)
          if (found < 0 && m_vld[k] && m_vpn[k] == int'(lookup_vaddr[31:12])) found = k;
        m_busy = 1;
        if (found >= 0) begin
          m_rem = found + 2; m_phit = 1; m_ppaddr = {found[7:0], lookup_vaddr[11:0]};
        end else begin
          m_rem = DEPTH + 1; m_phit = 0; m_ppaddr = '0;
        end
      end
    end
  end

  // Cycle compare against the reference, away from the active edge.
  always @(negedge clk) begin
    if (started) begin
      n_cmp++;
      if (busy !== m_busy || done !== m_done || hit !== m_hit || paddr !== m_paddr) begin
        n_bad++;
        $display("FAIL R2/R3/R9 cycle compare: busy=%b done=%b hit=%b paddr=%h expected busy=%b done=%b hit=%b paddr=%h",
                 busy, done, hit, paddr, m_busy, m_done, m_hit, m_paddr);
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_slot(input int frame, input int vpn, input bit load);
    wr_en = 1'b1; wr_load = load; wr_frame = frame[7:0]; wr_vpn = vpn[19:0];
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Start a lookup and wait for done; returns latency in edges after accept.
  task automatic lookup(input logic [31:0] va, output int lat, output logic h, output logic [19:0] pa);
    int n = 0;
    lookup_valid = 1'b1; lookup_vaddr = va;
    @(negedge clk);
    lookup_valid = 1'b0;
    n = 1;
    while (!done && n < 400) begin
      @(negedge clk);
      n++;
    end
    lat = n - 1; h = hit; pa = paddr;
  endtask

  int          lat;
  logic        h;
  logic [19:0] pa;

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 busy", {31'd0, busy}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 hit", {31'd0, hit}, 32'd0);
    check("R1 paddr", {12'd0, paddr}, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1 / R5: empty table misses after a full scan
    lookup(32'h12345678, lat, h, pa);
    check("R1 empty table hit", {31'd0, h}, 32'd0);
    check("R5 miss latency", lat, DEPTH + 1);
    check("R5 miss paddr", {12'd0, pa}, 32'd0);

    // R6 / R3 / R10: load frame 5 and find it
    write_slot(5, 20'hABCDE, 1);
    lookup(32'hABCDE123, lat, h, pa);
    check("R6 load then hit", {31'd0, h}, 32'd1);
    check("R3 hit latency", lat, 7);
    check("R10 paddr frame+offset", {12'd0, pa}, 32'h05123);

    // R9: result holds while idle
    repeat (5) @(negedge clk);
    check("R9 hold hit", {31'd0, hit}, 32'd1);
    check("R9 hold paddr", {12'd0, paddr}, 32'h05123);

    // R4: duplicate at higher slot, then at lower slot
    write_slot(200, 20'hABCDE, 1);
    lookup(32'hABCDE0F0, lat, h, pa);
    check("R4 lower slot kept", {12'd0, pa}, 32'h050F0);
    write_slot(3, 20'hABCDE, 1);
    lookup(32'hABCDE0F1, lat, h, pa);
    check("R4 lowest slot wins", {12'd0, pa}, 32'h030F1);
    check("R3 latency slot 3", lat, 5);

    // R8 / R6: invalidated slot is skipped despite equal contents
    write_slot(3, 0, 0);
    lookup(32'hABCDE777, lat, h, pa);
    check("R8 invalid slot skipped", {12'd0, pa}, 32'h05777);

    // R7 / R2: write and extra request during a search are dropped
    lookup_valid = 1'b1; lookup_vaddr = 32'h55555001;
    @(negedge clk);
    lookup_valid = 1'b0;
    repeat (3) @(negedge clk);
    write_slot(0, 20'h11111, 1);
    lookup_valid = 1'b1; lookup_vaddr = 32'hABCDE002;
    @(negedge clk);
    lookup_valid = 1'b0;
    while (!done) @(negedge clk);
    check("R2 request while busy ignored", {31'd0, hit}, 32'd0);
    lookup(32'h11111AAA, lat, h, pa);
    check("R7 write while busy dropped", {31'd0, h}, 32'd0);

    // R3: last slot
    write_slot(255, 20'hFFFFF, 1);
    lookup(32'hFFFFF9A5, lat, h, pa);
    check("R3 last slot hit", {31'd0, h}, 32'd1);
    check("R3 last slot latency", lat, DEPTH + 1);
    check("R10 last slot paddr", {12'd0, pa}, 32'hFF9A5);

    // R3 / R10: first slot, all-ones offset
    write_slot(0, 20'h00000, 1);
    lookup(32'h00000FFF, lat, h, pa);
    check("R3 first slot latency", lat, 2);
    check("R10 first slot paddr", {12'd0, pa}, 32'h00FFF);

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule